// File: doc/BRIEF.md
# Read-Port Scheduler with Deferred Third Operand

This block sits between a two-wide decode stage and a register file that has four read ports. Each cycle it hands read ports to the source operands of the two instructions issued together. Slot 0 operands take the lowest ports, and slot 1 operands take the ports after them. A three-source instruction is either a store with an index register or a multiply-add. When such an instruction would push the total demand above four ports, its third operand is not read in the issue cycle. Instead it is put into a small pending queue and read later, on a port that the current instructions leave idle. In effect the operation splits into a two-source read now and a one-source read later, so no read port has to be added.

Deferred multiply-add reads may go from the cycle after issue onwards. Deferred store-data reads must wait until a retire indication with the store's tag has been seen. By then the value is architecturally final, so the deferred read takes it straight from the register file with no forwarding path. The register file returns data one cycle after the port is driven. The block pairs that data with the tag of the deferred entry and raises a valid pulse on the port's return lane.

The queue has three named occupancy states. Q_EMPTY holds no entries. Q_PENDING holds one to three entries. Q_FULL holds all four. The transitions follow the entry count at the end of each cycle:
- EMPTY→PENDING or EMPTY→FULL when entries are added.
- PENDING→FULL when the last slot fills.
- PENDING→EMPTY when the last entry leaves.
- FULL→PENDING or FULL→EMPTY when entries leave.

A flush drops every pending entry except stores that are already retired.

Top module: `rps_sched`

## Requirements
- R1: During and directly after reset, no read port is enabled, no return pulse is raised, the stall output is low, and the queue is empty.
- R2: When the valid instructions need four or fewer sources in total, all of them are read in the issue cycle. Slot 0's sources go to ports 0 upward in source order (first, second, third). Slot 1's sources go to the next ports. Nothing is deferred.
- R3: When total demand exceeds four, every valid three-source instruction reads its first two sources in the issue cycle and defers its third. Port layout is slot 0's two sources, then slot 1's sources.
- R4: A deferred multiply-add read (store flag 0) can be granted in any cycle after its issue cycle.
- R5: A deferred store read (store flag 1) is not granted until a retire with its tag has been seen in an earlier cycle. It can be granted from the cycle after that retire.
- R6: Operands of the current instructions always get ports first. Deferred reads use only the ports left over, lowest free port first.
- R7: Among eligible deferred entries, older ones are served first. Slot 0 counts as older than slot 1 of the same cycle. An eligible younger entry may pass an ineligible older store. All spare ports may be used in one cycle.
- R8: One cycle after a deferred read is granted on port p, o_dv[p] pulses for one cycle with o_dtag[p] set to the entry's tag and o_ddata[p] set to the data the register file returns on that port.
- R9: The queue holds four entries. When the deferrals a cycle needs exceed the free entries counted at the start of that cycle, o_stall is high. In that cycle no current operand gets a port and nothing is queued. A cycle whose demand is four or fewer never stalls, even with a full queue.
- R10: With i_flush high, no deferred read is granted, no deferral from that cycle is queued, and all entries are dropped except stores whose retire was seen before or during the flush cycle.
- R11: The occupancy state is Q_FULL exactly when the queue holds four entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_flush | input | 1 | Discard unretired pending entries |
| i_vld | input | 2 | Instruction valid per slot |
| i_nsrc | input | 2x2 | Number of sources per slot (0 to 3) |
| i_src | input | 2x3x5 | Source register indices per slot |
| i_store | input | 2 | Three-source kind per slot: 1 store, 0 multiply-add |
| i_tag | input | 2x4 | Operation tag per slot |
| i_ret_vld | input | 1 | Retire indication valid |
| i_ret_tag | input | 4 | Tag of the retiring store |
| o_stall | output | 1 | Issue pair not accepted this cycle |
| o_rd_en | output | 4 | Read enable per port |
| o_rd_idx | output | 4x5 | Register index per port |
| i_rd_data | input | 4x32 | Data returned per port, one cycle after the read |
| o_dv | output | 4 | Deferred result valid per port lane |
| o_dtag | output | 4x4 | Tag of the deferred result |
| o_ddata | output | 4x32 | Data of the deferred result |

## Verification
Several properties are checked on every cycle:
- A deferred grant never lands on a port that a current operand holds.
- No store entry is granted before it is marked retired.
- A flush cycle grants nothing.
- The entry count never exceeds the depth, and the Q_FULL state matches a full queue.
- A stall takes no ports and queues nothing.
- Every return pulse follows a port enable in the cycle before.

Other behaviours can only be shown by the bench's scenarios:
- The exact port layout for each demand pattern.
- The order in which entries are served, including a multiply-add passing an unretired store.
- The one-cycle wait after a retire.
- Which entries survive a flush.
- That every deferred operand comes back exactly once with the register file's value.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PENDING = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;
endpackage

// File: rtl/rps_alloc.sv
module rps_alloc #(
    parameter int NPORT = 4,
    parameter int IDXW  = 5,
    parameter int TAGW  = 4,
    parameter int CNTW  = 3
) (
    input  logic [1:0]                  vld,
    input  logic [1:0][1:0]             nsrc,
    input  logic [1:0][2:0][IDXW-1:0]   src,
    input  logic [1:0]                  store,
    input  logic [1:0][TAGW-1:0]        tag,
    input  logic [CNTW-1:0]             free,
    output logic                        stall,
    output logic [NPORT-1:0]            cur_en,
    output logic [NPORT-1:0][IDXW-1:0]  cur_idx,
    output logic [1:0]                  def_req,
    output logic [1:0][IDXW-1:0]        def_idx,
    output logic [1:0][TAGW-1:0]        def_tag,
    output logic [1:0]                  def_st
);
    logic [2:0]      n0, n1, now0, now1, demand;
    logic [1:0]      three, defer;
    logic [CNTW-1:0] ndef;

    function automatic logic [IDXW-1:0] pick(input logic [2:0][IDXW-1:0] s, input logic [2:0] k);
        case (k)
            3'd0:    pick = s[0];
            3'd1:    pick = s[1];
            default: pick = s[2];
        endcase
    endfunction

    always_comb begin
        n0       = vld[0] ? {1'b0, nsrc[0]} : 3'd0;
        n1       = vld[1] ? {1'b0, nsrc[1]} : 3'd0;
        demand   = n0 + n1;
        three[0] = (n0 == 3'd3);
        three[1] = (n1 == 3'd3);
        defer    = (int'(demand) > NPORT) ? three : 2'b00;
        ndef     = CNTW'(defer[0]) + CNTW'(defer[1]);
        stall    = (ndef > free);
        now0     = n0 - {2'b00, defer[0]};
        now1     = n1 - {2'b00, defer[1]};
        def_req  = stall ? 2'b00 : defer;
        for (int s = 0; s < 2; s++) begin
            def_idx[s] = src[s][2];
            def_tag[s] = tag[s];
            def_st[s]  = store[s];
        end
        for (int p = 0; p < NPORT; p++) begin
            cur_en[p]  = 1'b0;
            cur_idx[p] = '0;
            if (!stall) begin
                if (3'(p) < now0) begin
                    cur_en[p]  = 1'b1;
                    cur_idx[p] = pick(src[0], 3'(p));
                end else if (3'(p) < now0 + now1) begin
                    cur_en[p]  = 1'b1;
                    cur_idx[p] = pick(src[1], 3'(p) - now0);
                end
            end
        end
    end
endmodule

// File: rtl/rps_defq.sv
module rps_defq
    import rps_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    parameter int IDXW  = 5,
    parameter int TAGW  = 4,
    parameter int CNTW  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [1:0]                  enq,
    input  logic [1:0][IDXW-1:0]        enq_idx,
    input  logic [1:0][TAGW-1:0]        enq_tag,
    input  logic [1:0]                  enq_st,
    input  logic                        ret_vld,
    input  logic [TAGW-1:0]             ret_tag,
    input  logic [NPORT-1:0]            port_busy,
    output logic [NPORT-1:0]            g_en,
    output logic [NPORT-1:0][IDXW-1:0]  g_idx,
    output logic [NPORT-1:0][TAGW-1:0]  g_tag,
    output logic [CNTW-1:0]             free
);
    localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic            e_vld [DEPTH];
    logic [IDXW-1:0] e_idx [DEPTH];
    logic [TAGW-1:0] e_tag [DEPTH];
    logic            e_st  [DEPTH];
    logic            e_ret [DEPTH];
    logic            n_vld [DEPTH];
    logic [IDXW-1:0] n_idx [DEPTH];
    logic [TAGW-1:0] n_tag [DEPTH];
    logic            n_st  [DEPTH];
    logic            n_ret [DEPTH];
    logic [DEPTH-1:0] ret_hit, elig, gnt;
    logic [CNTW-1:0] cnt, n_cnt;
    q_state_e        q_state, st_nxt;

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            ret_hit[e] = ret_vld && e_vld[e] && e_st[e] && (e_tag[e] == ret_tag);
            elig[e]    = e_vld[e] && (!e_st[e] || e_ret[e]);
        end
    end

    // oldest eligible entry takes the lowest port still free
    always_comb begin
        logic [NPORT-1:0] taken;
        logic             done;
        taken = port_busy;
        g_en  = '0;
        g_idx = '0;
        g_tag = '0;
        gnt   = '0;
        for (int e = 0; e < DEPTH; e++) begin
            done = 1'b0;
            if (elig[e] && !flush) begin
                for (int p = 0; p < NPORT; p++) begin
                    if (!done && !taken[p]) begin
                        done     = 1'b1;
                        taken[p] = 1'b1;
                        gnt[e]   = 1'b1;
                        g_en[p]  = 1'b1;
                        g_idx[p] = e_idx[e];
                        g_tag[p] = e_tag[e];
                    end
                end
            end
        end
    end

    // collapse survivors toward entry 0, then append new deferrals
    always_comb begin
        logic [CNTW-1:0] wp;
        logic            keep;
        wp = '0;
        for (int e = 0; e < DEPTH; e++) begin
            n_vld[e] = 1'b0;
            n_idx[e] = '0;
            n_tag[e] = '0;
            n_st[e]  = 1'b0;
            n_ret[e] = 1'b0;
        end
        for (int e = 0; e < DEPTH; e++) begin
            keep = e_vld[e] && !gnt[e] &&
                   (!flush || (e_st[e] && (e_ret[e] || ret_hit[e])));
            if (keep && int'(wp) < DEPTH) begin
                n_vld[wp[QW-1:0]] = 1'b1;
                n_idx[wp[QW-1:0]] = e_idx[e];
                n_tag[wp[QW-1:0]] = e_tag[e];
                n_st[wp[QW-1:0]]  = e_st[e];
                n_ret[wp[QW-1:0]] = e_ret[e] || ret_hit[e];
                wp = wp + 1'b1;
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (!flush && enq[k] && int'(wp) < DEPTH) begin
                n_vld[wp[QW-1:0]] = 1'b1;
                n_idx[wp[QW-1:0]] = enq_idx[k];
                n_tag[wp[QW-1:0]] = enq_tag[k];
                n_st[wp[QW-1:0]]  = enq_st[k];
                n_ret[wp[QW-1:0]] = 1'b0;
                wp = wp + 1'b1;
            end
        end
        n_cnt = wp;
    end

    always_comb begin
        st_nxt = q_state;
        unique case (q_state)
            Q_EMPTY:   if (n_cnt != 0) st_nxt = (int'(n_cnt) == DEPTH) ? Q_FULL : Q_PENDING;
            Q_PENDING: if (n_cnt == 0) st_nxt = Q_EMPTY;
                       else if (int'(n_cnt) == DEPTH) st_nxt = Q_FULL;
            Q_FULL:    if (int'(n_cnt) < DEPTH) st_nxt = (n_cnt == 0) ? Q_EMPTY : Q_PENDING;
            default:   st_nxt = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_state <= Q_EMPTY;
            cnt     <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                e_vld[e] <= 1'b0;
                e_idx[e] <= '0;
                e_tag[e] <= '0;
                e_st[e]  <= 1'b0;
                e_ret[e] <= 1'b0;
            end
        end else begin
            q_state <= st_nxt;
            cnt     <= n_cnt;
            for (int e = 0; e < DEPTH; e++) begin
                e_vld[e] <= n_vld[e];
                e_idx[e] <= n_idx[e];
                e_tag[e] <= n_tag[e];
                e_st[e]  <= n_st[e];
                e_ret[e] <= n_ret[e];
            end
        end
    end

    always_comb begin
        unique case (q_state)
            Q_EMPTY:   free = CNTW'(DEPTH);
            Q_FULL:    free = '0;
            default:   free = CNTW'(DEPTH) - cnt;
        endcase
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= DEPTH);
    // R6
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n) (g_en & port_busy) == '0);
    // R10
    flush_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |-> (g_en == '0));
    // R11
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == Q_FULL) == e_vld[DEPTH-1]);

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_chk
            // R5
            store_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt[e] && e_st[e]) |-> e_ret[e]);
        end
    endgenerate
endmodule

// File: rtl/rps_ret.sv
module rps_ret #(
    parameter int NPORT = 4,
    parameter int TAGW  = 4,
    parameter int DATAW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            g_en,
    input  logic [NPORT-1:0][TAGW-1:0]  g_tag,
    input  logic [NPORT-1:0][DATAW-1:0] rd_data,
    output logic [NPORT-1:0]            dv,
    output logic [NPORT-1:0][TAGW-1:0]  dtag,
    output logic [NPORT-1:0][DATAW-1:0] ddata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv   <= '0;
            dtag <= '0;
        end else begin
            dv   <= g_en;
            dtag <= g_tag;
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_lane
            assign ddata[p] = dv[p] ? rd_data[p] : '0;
        end
    endgenerate
endmodule

// File: rtl/rps_sched.sv
module rps_sched #(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    parameter int IDXW  = 5,
    parameter int TAGW  = 4,
    parameter int DATAW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        i_flush,
    input  logic [1:0]                  i_vld,
    input  logic [1:0][1:0]             i_nsrc,
    input  logic [1:0][2:0][IDXW-1:0]   i_src,
    input  logic [1:0]                  i_store,
    input  logic [1:0][TAGW-1:0]        i_tag,
    input  logic                        i_ret_vld,
    input  logic [TAGW-1:0]             i_ret_tag,
    output logic                        o_stall,
    output logic [NPORT-1:0]            o_rd_en,
    output logic [NPORT-1:0][IDXW-1:0]  o_rd_idx,
    input  logic [NPORT-1:0][DATAW-1:0] i_rd_data,
    output logic [NPORT-1:0]            o_dv,
    output logic [NPORT-1:0][TAGW-1:0]  o_dtag,
    output logic [NPORT-1:0][DATAW-1:0] o_ddata
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [CNTW-1:0]            free;
    logic [NPORT-1:0]           cur_en, g_en;
    logic [NPORT-1:0][IDXW-1:0] cur_idx, g_idx;
    logic [NPORT-1:0][TAGW-1:0] g_tag;
    logic [1:0]                 def_req, def_st;
    logic [1:0][IDXW-1:0]       def_idx;
    logic [1:0][TAGW-1:0]       def_tag;

    rps_alloc #(.NPORT(NPORT), .IDXW(IDXW), .TAGW(TAGW), .CNTW(CNTW)) u_alloc (
        .vld(i_vld), .nsrc(i_nsrc), .src(i_src), .store(i_store), .tag(i_tag),
        .free(free), .stall(o_stall), .cur_en(cur_en), .cur_idx(cur_idx),
        .def_req(def_req), .def_idx(def_idx), .def_tag(def_tag), .def_st(def_st)
    );

    rps_defq #(.NPORT(NPORT), .DEPTH(DEPTH), .IDXW(IDXW), .TAGW(TAGW), .CNTW(CNTW)) u_defq (
        .clk(clk), .rst_n(rst_n), .flush(i_flush),
        .enq(def_req), .enq_idx(def_idx), .enq_tag(def_tag), .enq_st(def_st),
        .ret_vld(i_ret_vld), .ret_tag(i_ret_tag), .port_busy(cur_en),
        .g_en(g_en), .g_idx(g_idx), .g_tag(g_tag), .free(free)
    );

    rps_ret #(.NPORT(NPORT), .TAGW(TAGW), .DATAW(DATAW)) u_ret (
        .clk(clk), .rst_n(rst_n), .g_en(g_en), .g_tag(g_tag), .rd_data(i_rd_data),
        .dv(o_dv), .dtag(o_dtag), .ddata(o_ddata)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign o_rd_en[p]  = cur_en[p] | g_en[p];
            assign o_rd_idx[p] = cur_en[p] ? cur_idx[p] : g_idx[p];
            // R8
            dv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                o_dv[p] |-> $past(o_rd_en[p]));
        end
    endgenerate

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_stall |-> (cur_en == '0 && def_req == 2'b00));
endmodule

// File: tb/rps_sched_test.sv
`timescale 1ns/1ps
module rps_sched_test;
    localparam int NPORT = 4, DEPTH = 4, IDXW = 5, TAGW = 4, DATAW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_flush = 1'b0;
    logic [1:0] i_vld = '0;
    logic [1:0][1:0] i_nsrc = '0;
    logic [1:0][2:0][IDXW-1:0] i_src = '0;
    logic [1:0] i_store = '0;
    logic [1:0][TAGW-1:0] i_tag = '0;
    logic i_ret_vld = 1'b0;
    logic [TAGW-1:0] i_ret_tag = '0;
    logic o_stall;
    logic [NPORT-1:0] o_rd_en;
    logic [NPORT-1:0][IDXW-1:0] o_rd_idx;
    logic [NPORT-1:0][DATAW-1:0] i_rd_data = '0;
    logic [NPORT-1:0] o_dv;
    logic [NPORT-1:0][TAGW-1:0] o_dtag;
    logic [NPORT-1:0][DATAW-1:0] o_ddata;

    int checks = 0;
    int fails = 0;
    int exp_tag[$];
    logic [DATAW-1:0] exp_data[$];

    always #4 clk = ~clk;

    rps_sched #(.NPORT(NPORT), .DEPTH(DEPTH), .IDXW(IDXW), .TAGW(TAGW), .DATAW(DATAW)) uut (.*);

    function automatic logic [DATAW-1:0] rf(input logic [IDXW-1:0] idx);
        rf = 32'hC0DE_0000 | {16'h0, 3'b0, idx, 3'b0, idx};
    endfunction

    always_ff @(posedge clk)
        for (int p = 0; p < NPORT; p++) i_rd_data[p] <= rf(o_rd_idx[p]);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_ports(input string req, input logic [3:0] en, input int i0, input int i1, input int i2, input int i3);
        int want [4];
        want = '{i0, i1, i2, i3};
        check(o_rd_en == en, req, 64'(o_rd_en), 64'(en));
        for (int p = 0; p < NPORT; p++)
            if (en[p]) check(o_rd_idx[p] == IDXW'(want[p]), req, 64'(o_rd_idx[p]), 64'(want[p]));
    endtask

    task automatic slot(input int s, input int n, input int a, input int b, input int c, input bit st, input int t);
        i_vld[s] = (n != 0);
        i_nsrc[s] = 2'(n);
        i_src[s][0] = IDXW'(a);
        i_src[s][1] = IDXW'(b);
        i_src[s][2] = IDXW'(c);
        i_store[s] = st;
        i_tag[s] = TAGW'(t);
    endtask

    task automatic idle();
        i_vld = '0;
        i_flush = 1'b0;
        i_ret_vld = 1'b0;
    endtask

    task automatic push_exp(input int t, input int idx);
        exp_tag.push_back(t);
        exp_data.push_back(rf(IDXW'(idx)));
    endtask

    task automatic next();
        @(negedge clk);
        idle();
    endtask

    // monitor: every return pulse must match a queued expectation (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NPORT; p++) begin
                if (o_dv[p]) begin
                    int hit;
                    hit = -1;
                    foreach (exp_tag[k]) if (hit < 0 && exp_tag[k] == int'(o_dtag[p])) hit = k;
                    check(hit >= 0, "R8 unexpected tag", 64'(o_dtag[p]), 64'hFFFF);
                    if (hit >= 0) begin
                        check(o_ddata[p] == exp_data[hit], "R8 data", 64'(o_ddata[p]), 64'(exp_data[hit]));
                        exp_tag.delete(hit);
                        exp_data.delete(hit);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(o_rd_en == '0 && o_dv == '0 && !o_stall, "R1", 64'({o_stall, o_dv, o_rd_en}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(o_rd_en == '0 && o_dv == '0 && !o_stall, "R1 after", 64'({o_stall, o_dv, o_rd_en}), 64'h0);

        // R2 two two-source ops
        slot(0, 2, 6, 7, 0, 0, 0); slot(1, 2, 8, 9, 0, 0, 0); #1;
        expect_ports("R2 2+2", 4'b1111, 6, 7, 8, 9);
        next();
        // R2 three-source store plus one-source op: exactly four, nothing deferred
        slot(0, 3, 10, 11, 12, 1, 0); slot(1, 1, 13, 0, 0, 0, 0); #1;
        expect_ports("R2 3+1", 4'b1111, 10, 11, 12, 13);
        next(); #1;
        expect_ports("R2 no deferral", 4'b0000, 0, 0, 0, 0);

        // R3/R4 multiply-add deferral
        next();
        slot(0, 3, 1, 2, 3, 0, 1); slot(1, 2, 4, 5, 0, 0, 2); #1;
        expect_ports("R3 3+2", 4'b1111, 1, 2, 4, 5);
        check(!o_stall, "R3 stall", 64'(o_stall), 64'h0);
        push_exp(1, 3);
        next(); #1;
        expect_ports("R4 madd next cycle", 4'b0001, 3, 0, 0, 0);
        next(); next();

        // R5 store waits for retire
        slot(0, 3, 14, 15, 16, 1, 3); slot(1, 2, 17, 18, 0, 0, 4); #1;
        expect_ports("R3 store", 4'b1111, 14, 15, 17, 18);
        push_exp(3, 16);
        for (int i = 0; i < 3; i++) begin
            next(); #1;
            expect_ports("R5 held", 4'b0000, 0, 0, 0, 0);
        end
        next();
        i_ret_vld = 1'b1; i_ret_tag = 4'd3; #1;
        expect_ports("R5 retire cycle", 4'b0000, 0, 0, 0, 0);
        next(); #1;
        expect_ports("R5 after retire", 4'b0001, 16, 0, 0, 0);
        next(); next();

        // R6 current operands first, deferred on lowest free port
        slot(0, 3, 1, 2, 19, 0, 5); slot(1, 2, 2, 3, 0, 0, 0); #1;
        push_exp(5, 19);
        next();
        slot(0, 2, 4, 5, 0, 0, 0); slot(1, 2, 6, 7, 0, 0, 0); #1;
        expect_ports("R6 ports full", 4'b1111, 4, 5, 6, 7);
        next();
        slot(0, 1, 8, 0, 0, 0, 0); #1;
        expect_ports("R6 leftover port", 4'b0011, 8, 19, 0, 0);
        next(); next();

        // R7 madd passes unretired store; two madds in age order
        slot(0, 3, 1, 2, 20, 1, 6); slot(1, 3, 3, 4, 21, 0, 7); #1;
        expect_ports("R3 3+3", 4'b1111, 1, 2, 3, 4);
        push_exp(6, 20); push_exp(7, 21);
        next(); #1;
        expect_ports("R7 pass store", 4'b0001, 21, 0, 0, 0);
        next();
        i_ret_vld = 1'b1; i_ret_tag = 4'd6;
        next(); #1;
        expect_ports("R7 store later", 4'b0001, 20, 0, 0, 0);
        next();
        slot(0, 3, 1, 2, 22, 0, 8); slot(1, 3, 3, 4, 23, 0, 9);
        push_exp(8, 22); push_exp(9, 23);
        next(); #1;
        expect_ports("R7 age order", 4'b0011, 22, 23, 0, 0);
        next(); next();

        // R9 fill queue then stall
        slot(0, 3, 1, 2, 24, 1, 10); slot(1, 3, 3, 4, 25, 1, 11);
        push_exp(10, 24); push_exp(11, 25);
        next();
        slot(0, 3, 1, 2, 26, 1, 12); slot(1, 3, 3, 4, 27, 1, 13);
        push_exp(12, 26); push_exp(13, 27);
        next();
        slot(0, 3, 5, 6, 28, 0, 14); slot(1, 2, 7, 8, 0, 0, 0); #1;
        check(o_stall, "R9 stall when full", 64'(o_stall), 64'h1);
        expect_ports("R9 no ports", 4'b0000, 0, 0, 0, 0);
        next();
        slot(0, 3, 5, 6, 28, 1, 0); slot(1, 1, 9, 0, 0, 0, 0); #1;
        check(!o_stall, "R9 demand four", 64'(o_stall), 64'h0);
        expect_ports("R9 demand four ports", 4'b1111, 5, 6, 28, 9);
        for (int t = 10; t < 14; t++) begin
            next();
            i_ret_vld = 1'b1; i_ret_tag = TAGW'(t);
        end
        repeat (3) next();

        // R10 flush keeps retired store only
        slot(0, 3, 1, 2, 29, 1, 15); slot(1, 3, 3, 4, 30, 0, 0);
        push_exp(15, 29);
        next();
        slot(0, 2, 4, 5, 0, 0, 0); slot(1, 2, 6, 7, 0, 0, 0);
        i_ret_vld = 1'b1; i_ret_tag = 4'd15;
        next();
        i_flush = 1'b1;
        slot(0, 3, 8, 9, 31, 0, 1); slot(1, 2, 10, 11, 0, 0, 0); #1;
        expect_ports("R10 flush cycle", 4'b1111, 8, 9, 10, 11);
        next(); #1;
        expect_ports("R10 retired kept", 4'b0001, 29, 0, 0, 0);
        next(); #1;
        expect_ports("R10 others dropped", 4'b0000, 0, 0, 0, 0);
        repeat (4) next();
        check(exp_tag.size() == 0, "R8 all returned", 64'(exp_tag.size()), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule